// File: doc/BRIEF.md
# Compressed Register-Pair Load/Store Decoder

This block sits in the decode stage of a 32-bit core. It recognises the four 16-bit instruction encodings that move a 64-bit value between memory and an even/odd register pair. Two of these forms take their base address from a register. The other two take it from the stack pointer. On a 64-bit core the same bit patterns mean ordinary doubleword load and store. Here they transfer the pair formed by an even register and the next odd register.

The decoder is purely combinational. It receives the instruction halfword and an enable that says whether pair transfers are implemented. It reports whether the word belongs to it, and if so:
- which transfer direction it encodes,
- the full 5-bit base register,
- the even data register that names the pair,
- a zero-extended byte offset,
- whether the instruction must trap as illegal.

Words outside the four forms produce a quiet "not mine" result. The rest of the compressed decoder handles those.

Top module: `cpair_decoder`

## Requirements
- R1: A word with bits 1:0 = 00 or 10 and bits 15:13 = 011 or 111 is claimed (`hit_o`=1). In that case `kind_o` is 01 (load) for funct3 011 and 10 (store) for funct3 111.
- R2: Any other word leaves `hit_o`, `kind_o`, `base_reg_o`, `data_reg_o`, `offset_o` and `illegal_o` all at zero. This includes every word whose bits 1:0 are 11.
- R3: In the register-based forms (bits 1:0 = 00), `offset_o` = {inst[6:5], inst[12:10], 3'b000}, zero-extended.
- R4: In the stack load (bits 1:0 = 10, funct3 011), `offset_o` = {inst[4:2], inst[12], inst[6:5], 3'b000}, zero-extended.
- R5: In the stack store (bits 1:0 = 10, funct3 111), `offset_o` = {inst[9:7], inst[12:10], 3'b000}, zero-extended.
- R6: In the register-based forms, `base_reg_o` = 8 + inst[9:7] and `data_reg_o` = 8 + inst[4:2].
- R7: In the stack forms, `base_reg_o` = 2. The stack load takes `data_reg_o` from inst[11:7]; the stack store takes it from inst[6:2].
- R8: A register-based form whose 3-bit data field inst[4:2] is odd (1, 3, 5 or 7) raises `illegal_o`.
- R9: The stack load raises `illegal_o` when inst[11:7] is zero or odd.
- R10: The stack store raises `illegal_o` when inst[6:2] is odd. A value of zero is legal.
- R11: With `pair_en_i`=0, every claimed word raises `illegal_o`. `hit_o`, `kind_o` and the decoded fields remain as for an enabled decoder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inst_i | input | 16 | Compressed instruction halfword |
| pair_en_i | input | 1 | Pair transfers implemented and enabled |
| hit_o | output | 1 | Word is one of the four pair forms |
| kind_o | output | 2 | 00 none, 01 load, 10 store |
| base_reg_o | output | REG_W (5) | Full base register index |
| data_reg_o | output | REG_W (5) | Even register naming the data pair |
| offset_o | output | OFS_W (12) | Zero-extended byte offset |
| illegal_o | output | 1 | Claimed word must raise illegal instruction |

## Verification
Two illegality sources can apply to the same word: the extension being disabled and a reserved odd or zero register field. The bench applies words that trip both at once, with `pair_en_i` low and an odd data field. The check is that `illegal_o` is a single asserted flag, while `hit_o`, `kind_o` and the decoded register and offset still follow R1 to R7. Words that trip only one of the two causes are applied as well, so that neither cause masks the other.

// File: rtl/cpair_pkg.sv
// Package: shared encodings for the compressed register-pair decoder.
// Assumes: 16-bit instruction words, quadrant in bits 1:0, funct3 in 15:13.
package cpair_pkg;

    // Transfer direction reported at the top-level port.
    typedef enum logic [1:0] {
        KIND_NONE  = 2'b00,
        KIND_LOAD  = 2'b01,
        KIND_STORE = 2'b10
    } pair_kind_e;

    // Which of the four recognised forms a word belongs to.
    typedef enum logic [2:0] {
        FORM_NONE   = 3'd0,
        FORM_REG_LD = 3'd1,
        FORM_REG_ST = 3'd2,
        FORM_SP_LD  = 3'd3,
        FORM_SP_ST  = 3'd4
    } pair_form_e;

    localparam logic [1:0] QUAD_REG = 2'b00;
    localparam logic [1:0] QUAD_SP  = 2'b10;
    localparam logic [2:0] F3_LOAD  = 3'b011;
    localparam logic [2:0] F3_STORE = 3'b111;

    // Compressed 3-bit register fields map onto x8..x15.
    localparam int unsigned CREG_BASE = 8;
    // Stack pointer register index.
    localparam int unsigned SP_INDEX  = 2;
    // Widest raw scaled offset produced by any form.
    localparam int unsigned RAW_OFS_W = 9;
    // Number of recognised forms.
    localparam int unsigned N_FORMS   = 4;

endpackage

// File: rtl/cpair_classify.sv
// Module: cpair_classify
// Matches quadrant and funct3 against the four pair forms.
// Produces the form code and the transfer direction.
// Assumes: at most one form can match, since each pairs a distinct quadrant and funct3.
module cpair_classify
    import cpair_pkg::*;
(
    input  logic [1:0] quad_i,
    input  logic [2:0] f3_i,
    output pair_form_e form_o,
    output pair_kind_e kind_o,
    output logic       hit_o
);

    // Match bit k: bit 1 of k selects the stack quadrant, bit 0 selects the store funct3.
    logic [N_FORMS-1:0] match;

    for (genvar k = 0; k < N_FORMS; k++) begin : g_match
        localparam logic [1:0] K_QUAD = (k / 2 == 1) ? QUAD_SP  : QUAD_REG;
        localparam logic [2:0] K_F3   = (k % 2 == 1) ? F3_STORE : F3_LOAD;
        // Compare the word against this form's quadrant and funct3.
        assign match[k] = (quad_i == K_QUAD) && (f3_i == K_F3);
    end

    // Encode the one-hot match vector into a form code and a direction.
    always_comb begin
        form_o = FORM_NONE;
        kind_o = KIND_NONE;
        if (match[0]) begin
            form_o = FORM_REG_LD;
            kind_o = KIND_LOAD;
        end else if (match[1]) begin
            form_o = FORM_REG_ST;
            kind_o = KIND_STORE;
        end else if (match[2]) begin
            form_o = FORM_SP_LD;
            kind_o = KIND_LOAD;
        end else if (match[3]) begin
            form_o = FORM_SP_ST;
            kind_o = KIND_STORE;
        end
    end

    assign hit_o = |match;

    // Guard: two forms can never claim the same word (R1).
    always_comb begin
        p_single_form_r1: assert ($onehot0(match))
            else $error("p_single_form_r1: several forms matched");
    end

endmodule

// File: rtl/cpair_fields.sv
// Module: cpair_fields
// Extracts the base register, the data register and the scaled offset for the decoded form.
// Assumes: ib_i carries instruction bits 12:2. Every output is zero for FORM_NONE.
module cpair_fields
    import cpair_pkg::*;
#(
    parameter int unsigned REG_W = 5,
    parameter int unsigned OFS_W = 12
) (
    input  pair_form_e        form_i,
    input  logic [12:2]       ib_i,
    output logic [REG_W-1:0]  base_o,
    output logic [REG_W-1:0]  data_o,
    output logic [OFS_W-1:0]  offset_o
);

    localparam logic [REG_W-1:0] CREG_OFS = REG_W'(CREG_BASE);
    localparam logic [REG_W-1:0] SP_REG   = REG_W'(SP_INDEX);

    logic [RAW_OFS_W-1:0] raw_ofs;

    // Assemble the scaled offset from the bit placement that belongs to each form.
    always_comb begin
        raw_ofs = '0;
        unique case (form_i)
            FORM_REG_LD,
            FORM_REG_ST: raw_ofs = {1'b0, ib_i[6:5], ib_i[12:10], 3'b000};
            FORM_SP_LD:  raw_ofs = {ib_i[4:2], ib_i[12], ib_i[6:5], 3'b000};
            FORM_SP_ST:  raw_ofs = {ib_i[9:7], ib_i[12:10], 3'b000};
            default:     raw_ofs = '0;
        endcase
    end

    // Select the base and data register indices for each form.
    always_comb begin
        base_o = '0;
        data_o = '0;
        unique case (form_i)
            FORM_REG_LD,
            FORM_REG_ST: begin
                base_o = CREG_OFS + REG_W'(ib_i[9:7]);
                data_o = CREG_OFS + REG_W'(ib_i[4:2]);
            end
            FORM_SP_LD: begin
                base_o = SP_REG;
                data_o = REG_W'(ib_i[11:7]);
            end
            FORM_SP_ST: begin
                base_o = SP_REG;
                data_o = REG_W'(ib_i[6:2]);
            end
            default: begin
                base_o = '0;
                data_o = '0;
            end
        endcase
    end

    // Zero-extend to the port width.
    assign offset_o = OFS_W'(raw_ofs);

    // Guard: every offset is a multiple of eight (R3).
    always_comb begin
        p_ofs_aligned_r3: assert (offset_o[2:0] == 3'b000)
            else $error("p_ofs_aligned_r3: offset not 8-byte aligned");
    end

endmodule

// File: rtl/cpair_legality.sv
// Module: cpair_legality
// Flags claimed words that must trap. A word traps when the extension is off,
// or when the data field names an odd register or (stack load only) x0.
// Assumes: for the register forms and the stack store, bit 2 is the low bit of the data field.
module cpair_legality
    import cpair_pkg::*;
(
    input  pair_form_e  form_i,
    input  logic        pair_en_i,
    input  logic        dlow_i,
    input  logic [4:0]  sprd_i,
    output logic        illegal_o
);

    logic bad_reg;

    // Find a reserved register field for the decoded form.
    always_comb begin
        bad_reg = 1'b0;
        unique case (form_i)
            FORM_REG_LD,
            FORM_REG_ST,
            FORM_SP_ST:  bad_reg = dlow_i;
            FORM_SP_LD:  bad_reg = (sprd_i == 5'd0) || sprd_i[0];
            default:     bad_reg = 1'b0;
        endcase
    end

    // Combine the two trap causes for claimed words only.
    assign illegal_o = (form_i != FORM_NONE) && (!pair_en_i || bad_reg);

endmodule

// File: rtl/cpair_decoder.sv
// Module: cpair_decoder
// Top level of the compressed register-pair load/store decoder for a 32-bit core.
// Purely combinational. Words outside the four forms give an all-zero "not mine" result.
// Assumes: OFS_W is at least 9 and REG_W is at least 5.
module cpair_decoder
    import cpair_pkg::*;
#(
    parameter int unsigned REG_W = 5,
    parameter int unsigned OFS_W = 12
) (
    input  logic [15:0]      inst_i,
    input  logic             pair_en_i,
    output logic             hit_o,
    output logic [1:0]       kind_o,
    output logic [REG_W-1:0] base_reg_o,
    output logic [REG_W-1:0] data_reg_o,
    output logic [OFS_W-1:0] offset_o,
    output logic             illegal_o
);

    pair_form_e form;
    pair_kind_e kind;

    cpair_classify u_classify (
        .quad_i (inst_i[1:0]),
        .f3_i   (inst_i[15:13]),
        .form_o (form),
        .kind_o (kind),
        .hit_o  (hit_o)
    );

    cpair_fields #(
        .REG_W (REG_W),
        .OFS_W (OFS_W)
    ) u_fields (
        .form_i   (form),
        .ib_i     (inst_i[12:2]),
        .base_o   (base_reg_o),
        .data_o   (data_reg_o),
        .offset_o (offset_o)
    );

    cpair_legality u_legality (
        .form_i    (form),
        .pair_en_i (pair_en_i),
        .dlow_i    (inst_i[2]),
        .sprd_i    (inst_i[11:7]),
        .illegal_o (illegal_o)
    );

    assign kind_o = kind;

    // Guards relating the outputs of the three separate sub-blocks.
    always_comb begin
        if (inst_i[1:0] == 2'b11) begin
            p_q3_unclaimed_r2: assert (!hit_o)
                else $error("p_q3_unclaimed_r2: 32-bit word claimed");
        end
        if (!hit_o) begin
            p_quiet_miss_r2: assert (!illegal_o && kind_o == 2'b00 && offset_o == '0
                                     && base_reg_o == '0 && data_reg_o == '0)
                else $error("p_quiet_miss_r2: unclaimed word drives outputs");
        end
        if (hit_o && !pair_en_i) begin
            p_disabled_traps_r11: assert (illegal_o)
                else $error("p_disabled_traps_r11: disabled pair form not illegal");
        end
        if (hit_o && !illegal_o) begin
            p_legal_even_r8: assert (!data_reg_o[0])
                else $error("p_legal_even_r8: legal word names odd register");
        end
        if (hit_o && inst_i[1:0] == QUAD_SP) begin
            p_sp_base_r7: assert (base_reg_o == REG_W'(SP_INDEX))
                else $error("p_sp_base_r7: stack form base not x2");
        end
        if (hit_o) begin
            p_kind_valid_r1: assert (kind_o == 2'b01 || kind_o == 2'b10)
                else $error("p_kind_valid_r1: claimed word without direction");
        end
    end

endmodule

// File: tb/cpair_decoder_bench.sv
// Directed bench for cpair_decoder. Each scenario task drives words and checks its own results.
module cpair_decoder_bench;

    localparam int unsigned REG_W = 5;
    localparam int unsigned OFS_W = 12;

    logic             clk = 1'b0;
    logic [15:0]      inst = 16'h0000;
    logic             en = 1'b1;
    logic             hit;
    logic [1:0]       kind;
    logic [REG_W-1:0] base_reg;
    logic [REG_W-1:0] data_reg;
    logic [OFS_W-1:0] offset;
    logic             illegal;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cpair_decoder #(.REG_W(REG_W), .OFS_W(OFS_W)) u_cpair_decoder (
        .inst_i     (inst),
        .pair_en_i  (en),
        .hit_o      (hit),
        .kind_o     (kind),
        .base_reg_o (base_reg),
        .data_reg_o (data_reg),
        .offset_o   (offset),
        .illegal_o  (illegal)
    );

    // Word builders, written from the bit layouts in the requirements.
    function automatic logic [15:0] mk_reg(input bit st, input int off, input int rs1, input int rd);
        logic [8:0] o = 9'(off);
        return {st ? 3'b111 : 3'b011, o[5:3], 3'(rs1), o[7:6], 3'(rd), 2'b00};
    endfunction

    function automatic logic [15:0] mk_spld(input int off, input int rd);
        logic [8:0] o = 9'(off);
        return {3'b011, o[5], 5'(rd), o[4:3], o[8:6], 2'b10};
    endfunction

    function automatic logic [15:0] mk_spst(input int off, input int rs2);
        logic [8:0] o = 9'(off);
        return {3'b111, o[5:3], o[8:6], 5'(rs2), 2'b10};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive a word between edges; sample 1 ns later.
    task automatic apply(input logic [15:0] w, input logic e);
        @(negedge clk);
        inst = w;
        en   = e;
        #1;
    endtask

    task automatic expect_all(input string req, input int h, input int k, input int b,
                              input int d, input int o, input int ill);
        chk(req, "hit", int'(hit), h);
        chk(req, "kind", int'(kind), k);
        chk(req, "base", int'(base_reg), b);
        chk(req, "data", int'(data_reg), d);
        chk(req, "offset", int'(offset), o);
        chk(req, "illegal", int'(illegal), ill);
    endtask

    // Idle word: all outputs at rest (R2).
    task automatic t_idle();
        apply(16'h0000, 1'b1);
        expect_all("R2", 0, 0, 0, 0, 0, 0);
    endtask

    // Register-based forms: direction, mapping and offset (R1, R3, R6).
    task automatic t_reg_forms();
        apply(mk_reg(1'b0, 248, 5, 2), 1'b1);
        expect_all("R1_R3_R6", 1, 1, 13, 10, 248, 0);
        apply(mk_reg(1'b1, 8, 0, 6), 1'b1);
        expect_all("R1_R3_R6", 1, 2, 8, 14, 8, 0);
        apply(mk_reg(1'b0, 136, 7, 4), 1'b1);
        expect_all("R3_R6", 1, 1, 15, 12, 136, 0);
    endtask

    // Stack load: base x2, destination field, offset layout (R4, R7).
    task automatic t_sp_load();
        apply(mk_spld(504, 10), 1'b1);
        expect_all("R4_R7", 1, 1, 2, 10, 504, 0);
        apply(mk_spld(40, 30), 1'b1);
        expect_all("R4_R7", 1, 1, 2, 30, 40, 0);
    endtask

    // Stack store: zero source allowed, offset layout (R5, R7, R10).
    task automatic t_sp_store();
        apply(mk_spst(0, 0), 1'b1);
        expect_all("R5_R10", 1, 2, 2, 0, 0, 0);
        apply(mk_spst(216, 30), 1'b1);
        expect_all("R5_R7", 1, 2, 2, 30, 216, 0);
        apply(mk_spst(504, 4), 1'b1);
        expect_all("R5_R7", 1, 2, 2, 4, 504, 0);
    endtask

    // Reserved register fields (R8, R9, R10).
    task automatic t_reserved();
        apply(mk_reg(1'b0, 16, 1, 3), 1'b1);
        expect_all("R8", 1, 1, 9, 11, 16, 1);
        apply(mk_reg(1'b1, 0, 2, 7), 1'b1);
        expect_all("R8", 1, 2, 10, 15, 0, 1);
        apply(mk_spld(8, 0), 1'b1);
        chk("R9", "illegal x0", int'(illegal), 1);
        apply(mk_spld(8, 9), 1'b1);
        chk("R9", "illegal odd", int'(illegal), 1);
        apply(mk_spld(8, 2), 1'b1);
        chk("R9", "illegal even", int'(illegal), 0);
        apply(mk_spst(8, 5), 1'b1);
        chk("R10", "illegal odd", int'(illegal), 1);
    endtask

    // Extension disabled, alone and together with an odd field (R11).
    task automatic t_disabled();
        apply(mk_reg(1'b0, 8, 3, 2), 1'b0);
        expect_all("R11", 1, 1, 11, 10, 8, 1);
        apply(mk_reg(1'b1, 8, 3, 2), 1'b0);
        expect_all("R11", 1, 2, 11, 10, 8, 1);
        apply(mk_spld(16, 4), 1'b0);
        expect_all("R11", 1, 1, 2, 4, 16, 1);
        apply(mk_spst(16, 4), 1'b0);
        expect_all("R11", 1, 2, 2, 4, 16, 1);
        apply(mk_reg(1'b0, 24, 4, 5), 1'b0);
        expect_all("R11_R8", 1, 1, 12, 13, 24, 1);
    endtask

    // Words that belong elsewhere (R2).
    task automatic t_not_mine();
        apply({3'b011, 11'h7FF, 2'b11}, 1'b1);
        expect_all("R2", 0, 0, 0, 0, 0, 0);
        apply({3'b011, 11'h2A5, 2'b01}, 1'b1);
        expect_all("R2", 0, 0, 0, 0, 0, 0);
        apply({3'b010, 11'h155, 2'b00}, 1'b0);
        expect_all("R2", 0, 0, 0, 0, 0, 0);
        apply({3'b001, 11'h0F3, 2'b10}, 1'b1);
        expect_all("R2", 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_idle();
        t_reg_forms();
        t_sp_load();
        t_sp_store();
        t_reserved();
        t_disabled();
        t_not_mine();
        finish_run();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule